// File: doc/BRIEF.md
# Recursive Vertical-Crosswise Mantissa Multiplier

This block multiplies two unsigned 24-bit operands and returns their full 48-bit product without any clock or pipeline stage. It is meant to sit at the heart of a single-precision floating-point multiplier. There it takes the two significands, each a hidden one plus a 23-bit fraction, and hands back the raw product for the normalise and round logic that follows. Sign handling, exponent handling and rounding belong to the surrounding logic.

The multiplier is a recursive tree. A 3x3 leaf forms its column sums from the vertical and crosswise bit products, using half adders, full adders and a two-bit adder. Each wider level cuts both operands into an upper and a lower half, runs four half-width multipliers, and merges their results with three adders:

1. The first adder sums the two cross terms.
2. The second adds the upper half of the low-by-low product.
3. The third folds the result into the high-by-high product.

The low half of the low-by-low product goes straight to the output. The levels are 3, 6, 12 and 24 bits wide. Levels narrower than a parameter threshold use Brent-Kung prefix adders. Levels at or above the threshold use carry-select adders, which precompute each block's sum for both carry-in values and pick one with a multiplexer.

Top module: `vcm_mul24`

## Requirements
- R1: For every pair of 24-bit unsigned operands, `prod` equals the exact 48-bit product `opa * opb`.
- R2: When either operand is zero, `prod` is zero.
- R3: When one operand equals 1, `prod` equals the other operand zero-extended to 48 bits.
- R4: Squaring the all-ones operand 0xFFFFFF gives 0xFFFFFE000001.
- R5: When bit 23 of both operands is set, bit 47 or bit 46 of `prod` is set. 0x800000 squared gives exactly 0x400000000000, with only bit 46 set. 0x800000 times 0xFFFFFF gives 0x7FFFFF800000.
- R6: The 3x3 leaf level gives the exact 6-bit product for all 64 operand pairs.
- R7: The 6-bit level, used alone, gives the exact 12-bit product for all 4096 operand pairs.
- R8: The 12-bit level gives the exact 24-bit product whether its adders are prefix adders or carry-select adders.
- R9: The prefix adder at 25 bits returns `s = (a + b + cin) mod 2^25` and `cout` as the carry out of bit 24.
- R10: The carry-select adder at 25 bits with 4-bit blocks returns the same sum and carry as in R9, including the case where the final block is only 1 bit wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 24 | First unsigned operand (significand with hidden bit) |
| opb | input | 24 | Second unsigned operand |
| prod | output | 48 | Full unsigned product of `opa` and `opb` |

## Verification
The bench builds the top at its defaults, a 24-bit width with carry-select adders only at the 24-bit level. This is checked against corner operands, walking-one pairs and thousands of random pairs.

It also builds the recursion alone at other widths:
- At 3 and 6 bits, exhaustive operand sweeps become affordable.
- At 12 bits it is built twice, once with the carry-select threshold lowered to 12. This checks the recursion with both adder kinds at the same level.

Both adders are also built alone at 25 bits, so that the uneven last carry-select block and long carry chains can be driven directly.

// File: rtl/vcm_pkg.sv
// Package: shared constants and bit-level adder cells for the multiplier tree.
// Assumes: the leaf width is fixed at 3 bits by the leaf's own structure.
package vcm_pkg;

    localparam int VCM_LEAF_W = 3;

    // Half adder cell: returns {carry, sum}.
    function automatic logic [1:0] vcm_ha(input logic x, input logic y);
        return {x & y, x ^ y};
    endfunction

    // Full adder cell: returns {carry, sum}.
    function automatic logic [1:0] vcm_fa(input logic x, input logic y, input logic z);
        return {(x & y) | (z & (x ^ y)), x ^ y ^ z};
    endfunction

endpackage

// File: rtl/vcm_leaf3.sv
// Module: 3x3 vertical-crosswise multiplier leaf.
// Forms the nine bit products and reduces each column with half adders,
// full adders and a final two-bit adder. Purely combinational.
module vcm_leaf3
    import vcm_pkg::*;
(
    input  logic [2:0] a,
    input  logic [2:0] b,
    output logic [5:0] p
);

    logic [1:0] col1, col2_fa, col2_ha, col3_fa;
    logic [2:0] top2;

    // Column reduction from bit 0 upward.
    always_comb begin
        col1    = vcm_ha(a[1] & b[0], a[0] & b[1]);
        col2_fa = vcm_fa(a[2] & b[0], a[1] & b[1], a[0] & b[2]);
        col2_ha = vcm_ha(col2_fa[0], col1[1]);
        col3_fa = vcm_fa(a[2] & b[1], a[1] & b[2], col2_ha[1]);
        top2    = {1'b0, a[2] & b[2], col3_fa[0]} + {1'b0, col3_fa[1], col2_fa[1]};
        p       = {top2, col2_ha[0], col1[0], a[0] & b[0]};
    end

endmodule

// File: rtl/vcm_bk_add.sv
// Module: Brent-Kung parallel-prefix adder of parameter width W.
// Up-sweep builds group generate/propagate at power-of-two spans, and the
// down-sweep fills in the remaining prefixes. Assumes W >= 2.
module vcm_bk_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);

    localparam int L = $clog2(W);

    logic [W-1:0] g, pp, t;

    // Prefix network evaluated in place; targets never alias partners in a level.
    always_comb begin
        t     = a ^ b;
        g     = a & b;
        pp    = t;
        g[0]  = (a[0] & b[0]) | (t[0] & cin);
        for (int l = 0; l < L; l++) begin
            for (int i = 0; i < W; i++) begin
                if (((i + 1) % (2 << l)) == 0) begin
                    g[i]  = g[i] | (pp[i] & g[i - (1 << l)]);
                    pp[i] = pp[i] & pp[i - (1 << l)];
                end
            end
        end
        for (int l = L - 2; l >= 0; l--) begin
            for (int i = 0; i < W; i++) begin
                if (((i + 1) % (2 << l)) == (1 << l) && (i + 1) >= 3 * (1 << l)) begin
                    g[i]  = g[i] | (pp[i] & g[i - (1 << l)]);
                    pp[i] = pp[i] & pp[i - (1 << l)];
                end
            end
        end
        s    = t ^ {g[W-2:0], cin};
        cout = g[W-1];
    end

endmodule

// File: rtl/vcm_csel_add.sv
// Module: multiplexer-based carry-select adder of width W in BLK-bit blocks.
// Each block precomputes its sum for carry-in 0 and 1; the carry chain only
// drives selectors. The last block may be narrower than BLK.
module vcm_csel_add #(
    parameter int W   = 24,
    parameter int BLK = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);

    localparam int NB = (W + BLK - 1) / BLK;

    wire [NB:0]  c;
    wire [W-1:0] s_w;

    assign c[0] = cin;

    for (genvar k = 0; k < NB; k++) begin : g_blk
        localparam int LO = k * BLK;
        localparam int BW = (W - LO < BLK) ? (W - LO) : BLK;
        wire [BW:0] r0, r1;
        // Both candidate sums of this block, then the carry-driven pick.
        assign r0 = {1'b0, a[LO +: BW]} + {1'b0, b[LO +: BW]};
        assign r1 = {1'b0, a[LO +: BW]} + {1'b0, b[LO +: BW]} + {{BW{1'b0}}, 1'b1};
        assign s_w[LO +: BW] = c[k] ? r1[BW-1:0] : r0[BW-1:0];
        assign c[k+1]        = c[k] ? r1[BW]     : r0[BW];
    end

    assign s    = s_w;
    assign cout = c[NB];

endmodule

// File: rtl/vcm_add.sv
// Module: adder selector; picks the carry-select or the prefix adder.
// USE_MUX is fixed at elaboration by the enclosing level.
module vcm_add #(
    parameter int W       = 8,
    parameter bit USE_MUX = 1'b0,
    parameter int BLK     = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);

    if (USE_MUX) begin : g_csel
        vcm_csel_add #(.W(W), .BLK(BLK)) u_add (.a(a), .b(b), .cin(cin), .s(s), .cout(cout));
    end else begin : g_bk
        vcm_bk_add #(.W(W)) u_add (.a(a), .b(b), .cin(cin), .s(s), .cout(cout));
    end

endmodule

// File: rtl/vcm_level.sv
// Module: one recursion level of width W of the multiplier tree.
// At the leaf width it wraps the 3x3 cell; above it, it splits each operand
// in halves, builds four half-width products and merges them with three
// adders. Assumes W = 3 * 2^k. Levels of width >= MUX_MIN_W use carry-select.
module vcm_level
    import vcm_pkg::*;
#(
    parameter int W         = 6,
    parameter int MUX_MIN_W = 24,
    parameter int CSEL_BLK  = 4
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    localparam int H       = W / 2;
    localparam bit USE_MUX = (W >= MUX_MIN_W);

    if (W == VCM_LEAF_W) begin : g_leaf
        vcm_leaf3 u_leaf (.a(a), .b(b), .p(p));
    end else begin : g_split
        logic [W-1:0] p_ll, p_lh, p_hl, p_hh;
        logic [W-1:0] cross_s, mid_s;
        logic         cross_c, mid_c;
        logic [H:0]   mid_top;
        logic [W-2:0] hi_s;
        logic         hi_c;

        vcm_level #(.W(H), .MUX_MIN_W(MUX_MIN_W), .CSEL_BLK(CSEL_BLK))
            u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_ll));
        vcm_level #(.W(H), .MUX_MIN_W(MUX_MIN_W), .CSEL_BLK(CSEL_BLK))
            u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(p_lh));
        vcm_level #(.W(H), .MUX_MIN_W(MUX_MIN_W), .CSEL_BLK(CSEL_BLK))
            u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(p_hl));
        vcm_level #(.W(H), .MUX_MIN_W(MUX_MIN_W), .CSEL_BLK(CSEL_BLK))
            u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(p_hh));

        // Adder 1: sum of the two cross terms.
        vcm_add #(.W(W), .USE_MUX(USE_MUX), .BLK(CSEL_BLK))
            u_cross (.a(p_hl), .b(p_lh), .cin(1'b0), .s(cross_s), .cout(cross_c));

        // Adder 2: add the upper half of the low product to the cross sum.
        vcm_add #(.W(W), .USE_MUX(USE_MUX), .BLK(CSEL_BLK))
            u_mid (.a(cross_s), .b({{(W-H){1'b0}}, p_ll[W-1:H]}), .cin(1'b0),
                   .s(mid_s), .cout(mid_c));

        // Both carries can never be set together, so they merge with OR.
        assign mid_top = {cross_c | mid_c, mid_s[W-1:H]};

        // Adder 3: fold into the high product; its top bit takes the carry.
        vcm_add #(.W(W-1), .USE_MUX(USE_MUX), .BLK(CSEL_BLK))
            u_hi (.a(p_hh[W-2:0]), .b({{(W-H-2){1'b0}}, mid_top}), .cin(1'b0),
                  .s(hi_s), .cout(hi_c));

        assign p = {p_hh[W-1] ^ hi_c, hi_s, mid_s[H-1:0], p_ll[H-1:0]};
    end

endmodule

// File: rtl/vcm_mul24.sv
// Module: top of the 24x24 unsigned mantissa multiplier.
// Purely combinational; OP_W must be 3 * 2^k.
module vcm_mul24 #(
    parameter int OP_W      = 24,
    parameter int MUX_MIN_W = 24,
    parameter int CSEL_BLK  = 4
) (
    input  logic [OP_W-1:0]   opa,
    input  logic [OP_W-1:0]   opb,
    output logic [2*OP_W-1:0] prod
);

    vcm_level #(.W(OP_W), .MUX_MIN_W(MUX_MIN_W), .CSEL_BLK(CSEL_BLK))
        u_core (.a(opa), .b(opb), .p(prod));

endmodule

// File: rtl/vcm_mul24_chk.sv
// Module: assertion checker for vcm_mul24, attached by bind.
// Immediate checks on settled port values; skipped while inputs are unknown.
module vcm_mul24_chk #(
    parameter int OP_W = 24
) (
    input logic [OP_W-1:0]   opa,
    input logic [OP_W-1:0]   opb,
    input logic [2*OP_W-1:0] prod
);

    logic [2*OP_W-1:0] wide_a, wide_b;

    assign wide_a = {{OP_W{1'b0}}, opa};
    assign wide_b = {{OP_W{1'b0}}, opb};

    // Port relations checked whenever inputs or output change.
    always_comb begin
        if (!$isunknown({opa, opb, prod})) begin
            AST_PRODUCT_EXACT: assert (prod == wide_a * wide_b); // R1
            AST_ZERO_OPERAND: assert (!(opa == '0 || opb == '0) || prod == '0); // R2
            AST_UNIT_OPERAND: assert (!(opb == OP_W'(1)) || prod == wide_a); // R3
            AST_ALL_ONES_SQUARE: assert (!(&opa && &opb) || prod == {{(OP_W-1){1'b1}}, 1'b0, {(OP_W-1){1'b0}}, 1'b1}); // R4
            AST_NORMALISED_TOP: assert (!(opa[OP_W-1] && opb[OP_W-1]) || (prod[2*OP_W-1] | prod[2*OP_W-2])); // R5
        end
    end

endmodule

bind vcm_mul24 vcm_mul24_chk #(.OP_W(OP_W)) u_chk (.opa(opa), .opb(opb), .prod(prod));

// File: tb/tb_vcm_mul24.sv
`timescale 1ns/1ps
// Bench: drives the top, standalone levels and both adders on each falling
// edge and compares against a behavioural integer model one ns later.
module tb_vcm_mul24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    logic [23:0] a24 = '0, b24 = '0;
    logic [47:0] p24;
    logic [2:0]  a3 = '0, b3 = '0;
    logic [5:0]  p3;
    logic [5:0]  a6 = '0, b6 = '0;
    logic [11:0] p6;
    logic [11:0] a12 = '0, b12 = '0;
    logic [23:0] p12, p12m;
    logic [24:0] xa = '0, xb = '0;
    logic        xcin = 1'b0;
    logic [24:0] s_bk, s_cs;
    logic        c_bk, c_cs;

    vcm_mul24 dut (.opa(a24), .opb(b24), .prod(p24));
    vcm_level #(.W(3))  u_l3  (.a(a3),  .b(b3),  .p(p3));
    vcm_level #(.W(6))  u_l6  (.a(a6),  .b(b6),  .p(p6));
    vcm_level #(.W(12)) u_l12 (.a(a12), .b(b12), .p(p12));
    vcm_level #(.W(12), .MUX_MIN_W(12)) u_l12m (.a(a12), .b(b12), .p(p12m));
    vcm_bk_add   #(.W(25))           u_bk (.a(xa), .b(xb), .cin(xcin), .s(s_bk), .cout(c_bk));
    vcm_csel_add #(.W(25), .BLK(4))  u_cs (.a(xa), .b(xb), .cin(xcin), .s(s_cs), .cout(c_cs));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_top(input logic [23:0] x, input logic [23:0] y, input string tag);
        @(negedge clk);
        a24 = x;
        b24 = y;
        #1;
        check(tag, {16'b0, p24}, 64'(x) * 64'(y));
    endtask

    task automatic run_add(input logic [24:0] x, input logic [24:0] y, input logic ci);
        logic [63:0] e;
        @(negedge clk);
        xa = x;
        xb = y;
        xcin = ci;
        #1;
        e = 64'(x) + 64'(y) + 64'(ci);
        check("R9 prefix adder", {38'b0, c_bk, s_bk}, e);
        check("R10 carry-select adder", {38'b0, c_cs, s_cs}, e);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        #1;
        check("R2 reset state", {16'b0, p24}, 64'd0);
        rst_n = 1'b1;

        run_top(24'h000000, 24'hFFFFFF, "R2 zero a");
        run_top(24'hABCDEF, 24'h000000, "R2 zero b");
        run_top(24'h000001, 24'h5A5A5A, "R3 one a");
        run_top(24'hC3C3C3, 24'h000001, "R3 one b");
        run_top(24'h000001, 24'h000001, "R3 one one");
        run_top(24'hFFFFFF, 24'hFFFFFF, "R4 all ones");
        check("R4 constant", {16'b0, p24}, 64'h0000_FFFF_FE00_0001);
        run_top(24'h800000, 24'h800000, "R5 min hidden");
        check("R5 constant min", {16'b0, p24}, 64'h0000_4000_0000_0000);
        run_top(24'h800000, 24'hFFFFFF, "R5 min by max");
        check("R5 constant mix", {16'b0, p24}, 64'h0000_7FFF_FF80_0000);

        for (int i = 0; i < 24; i++) begin
            for (int j = 0; j < 24; j++) begin
                run_top(24'(1) << i, 24'(1) << j, "R1 walking ones");
            end
        end
        for (int n = 0; n < 5000; n++) begin
            run_top(24'($urandom()), 24'($urandom()), "R1 random");
        end
        for (int n = 0; n < 300; n++) begin
            logic [23:0] x, y;
            x = 24'($urandom()) | 24'h800000;
            y = 24'($urandom()) | 24'h800000;
            run_top(x, y, "R5 normalised random");
            check("R5 top bits", {63'b0, p24[47] | p24[46]}, 64'd1);
        end

        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                @(negedge clk);
                a3 = 3'(i);
                b3 = 3'(j);
                #1;
                check("R6 leaf", {58'b0, p3}, 64'(i * j));
            end
        end

        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                @(negedge clk);
                a6 = 6'(i);
                b6 = 6'(j);
                #1;
                check("R7 six-bit level", {52'b0, p6}, 64'(i * j));
            end
        end

        for (int n = 0; n < 2000; n++) begin
            logic [11:0] x, y;
            x = 12'($urandom());
            y = (n == 0) ? 12'hFFF : 12'($urandom());
            if (n == 0) x = 12'hFFF;
            @(negedge clk);
            a12 = x;
            b12 = y;
            #1;
            check("R8 twelve-bit prefix", {40'b0, p12}, 64'(x) * 64'(y));
            check("R8 twelve-bit carry-select", {40'b0, p12m}, 64'(x) * 64'(y));
        end

        run_add(25'h1FFFFFF, 25'h0000000, 1'b1);
        run_add(25'h1FFFFFF, 25'h1FFFFFF, 1'b1);
        run_add(25'h0000000, 25'h0000000, 1'b0);
        run_add(25'h0FFFFFF, 25'h0000001, 1'b0);
        for (int n = 0; n < 1000; n++) begin
            run_add(25'($urandom()), 25'($urandom()), 1'($urandom()));
        end

        finish_run();
    end

endmodule